// File: doc/BRIEF.md
# Interrupt Distributor

This block holds per-interrupt routing state for a small interrupt controller. Each interrupt ID has an enable bit, a pending state, a trigger mode, an 8-bit priority and a CPU target mask. All of this state is set and read through a plain 32-bit word-wide register port. Interrupt IDs 0 to 15 are software interrupts: they have no input pin, they are always enabled, and they always behave as edge-triggered. IDs 16 and up each take one peripheral input line, `src_i[id-16]`. IDs from 32 up are the shared range. In this block they are treated the same as 16 to 31.

For each CPU, the block continuously offers one interrupt. It is the most urgent one that is pending, enabled and targeted at that CPU. The offer is made only while the global forwarding bit is set. The result is a combinational function of the stored state, so it changes in the same cycle that the state changes.

Register layout (byte addresses; every access is a full word):
- `0x000`: control register.
- Enable state: write-one-to-set at `0x100 + 4*(id/32)`, write-one-to-clear at `0x180 + 4*(id/32)`.
- Pending state: write-one-to-set at `0x200 + 4*(id/32)`, write-one-to-clear at `0x280 + 4*(id/32)`.
- Priority: `0x400 + 4*(id/4)`.
- Target: `0x800 + 4*(id/4)`.
- Trigger configuration: `0xC00 + 4*(id/16)`.

Top module: `irq_dist`

## Requirements
- R1: Enable bits of IDs 0–15 always read 1, and set-enable or clear-enable writes leave them at 1. Those IDs are always edge mode (their configuration bit 2*(id%16)+1 reads 1).
- R2: A 1 at bit id%32 of a set-enable word enables that ID, and a 1 in the clear-enable word disables it. Zero bits change nothing. Both banks read back the current enable bits.
- R3: A 1 at bit id%32 of a set-pending word makes the ID pending. A 1 in the clear-pending word removes the latched pending state. Both banks read back the current pending state.
- R4: Bit 2*(id%16)+1 of a configuration word selects edge mode when 1. In edge mode, a rising edge on the input latches pending two clock edges after the input rises. The latch stays set after the input falls, until it is cleared by software.
- R5: In level mode (bit 0), the ID is pending from the first clock edge that samples its input high, until the first edge that samples it low, unless it is latched by software.
- R6: Priority is 8 bits per ID, in byte lane id%4 of its word. It resets to 0.
- R7: The target mask is 8 bits per ID, in byte lane id%4. Bit k routes the ID to CPU k. Mask bits at NUM_CPU and above read 0. Reset value is 1, which routes to CPU 0.
- R8: Bit 0 of the control word is the global enable. While it is 0, no CPU has an offered interrupt.
- R9: CPU k is offered the pending, enabled ID with bit k set in its target mask that has the lowest priority value. A tie goes to the lower ID. `hit_id_o` and `hit_prio_o` read 0 when nothing is offered.
- R10: Bits for IDs at or above NUM_IRQ read 0 and ignore writes. Undecoded addresses read 0.
- R11: After reset:
  - IDs 16 and up are disabled and level-mode.
  - Nothing is pending.
  - Global enable is off.
- R12: Read data appears on `rdata_o` at the clock edge that accepts the read request, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| src_i | input | NUM_IRQ-16 | Peripheral interrupt inputs; bit j drives ID j+16 |
| hit_o | output | NUM_CPU | Per-CPU interrupt offered |
| hit_id_o | output | NUM_CPU*$clog2(NUM_IRQ) | Per-CPU offered ID |
| hit_prio_o | output | NUM_CPU*8 | Per-CPU offered priority |

## Verification
The bench builds the block with NUM_IRQ=48 and NUM_CPU=3.

With 48 IDs, the second enable and pending words are only half implemented, and the third word is empty. This puts the read-as-zero rule for IDs past NUM_IRQ within reach. With 3 CPUs, target masks have five unimplemented bits per byte, and each CPU sees a different subset of the interrupts. Random mixes of priorities, trigger modes and input toggles then exercise the tie-break and the per-CPU filtering against a model.

// File: rtl/irq_dist_pkg.sv
`timescale 1ns/1ps
package irq_dist_pkg;
  localparam int unsigned PRIO_W = 8;
  localparam int unsigned TGT_W  = 8;

  typedef enum logic [2:0] {
    RG_NONE, RG_CTRL, RG_EN, RG_PND, RG_PRIO, RG_TGT, RG_CFG
  } region_e;

  function automatic region_e region_of(logic [11:0] a);
    if (a[11:10] == 2'b01) return RG_PRIO;
    if (a[11:10] == 2'b10) return RG_TGT;
    if (a[11:10] == 2'b11) return RG_CFG;
    if (a[9:8] == 2'b01) return RG_EN;
    if (a[9:8] == 2'b10) return RG_PND;
    if (a[9:2] == 8'd0) return RG_CTRL;
    return RG_NONE;
  endfunction
endpackage

// File: rtl/irq_dist_line.sv
`timescale 1ns/1ps
module irq_dist_line #(
  parameter int unsigned ID      = 0,
  parameter int unsigned NUM_CPU = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               src_i,
  input  logic               set_en_i,
  input  logic               clr_en_i,
  input  logic               set_pnd_i,
  input  logic               clr_pnd_i,
  input  logic               cfg_we_i,
  input  logic               cfg_edge_i,
  input  logic               prio_we_i,
  input  logic [7:0]         prio_i,
  input  logic               tgt_we_i,
  input  logic [NUM_CPU-1:0] tgt_i,
  output logic               en_o,
  output logic               pend_o,
  output logic               edge_o,
  output logic [7:0]         prio_o,
  output logic [NUM_CPU-1:0] tgt_o
);
  logic [7:0]         prio_q;
  logic [NUM_CPU-1:0] tgt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q <= '0;
      tgt_q  <= NUM_CPU'(1);
    end else begin
      if (prio_we_i) prio_q <= prio_i;
      if (tgt_we_i)  tgt_q  <= tgt_i;
    end
  end

  assign prio_o = prio_q;
  assign tgt_o  = tgt_q;

  if (ID < 16) begin : g_sgi
    logic pnd_q;
    logic unused_sgi;
    assign unused_sgi = ^{src_i, set_en_i, clr_en_i, cfg_we_i, cfg_edge_i};

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pnd_q <= 1'b0;
      else         pnd_q <= (pnd_q & ~clr_pnd_i) | set_pnd_i;
    end

    assign en_o   = 1'b1;
    assign edge_o = 1'b1;
    assign pend_o = pnd_q;

    p_sgi_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_pnd_i |=> pend_o);
  end else begin : g_per
    logic en_q, edge_q, pnd_q, src_q, src_qq;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q   <= 1'b0;
        edge_q <= 1'b0;
        pnd_q  <= 1'b0;
        src_q  <= 1'b0;
        src_qq <= 1'b0;
      end else begin
        en_q   <= (en_q | set_en_i) & ~clr_en_i;
        if (cfg_we_i) edge_q <= cfg_edge_i;
        src_q  <= src_i;
        src_qq <= src_q;
        // a hardware edge in the same cycle as a software clear is kept
        pnd_q  <= (pnd_q & ~clr_pnd_i) | set_pnd_i | (edge_q & src_q & ~src_qq);
      end
    end

    assign en_o   = en_q;
    assign edge_o = edge_q;
    assign pend_o = pnd_q | (~edge_q & src_q);

    p_set_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_en_i && !clr_en_i) |=> en_o);
    p_clr_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_en_i |=> !en_o);
    p_set_pnd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_pnd_i |=> pend_o);
    p_edge_latch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_o && src_q && !src_qq) |=> pend_o);
    p_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!edge_o && src_q) |-> pend_o);
  end
endmodule

// File: rtl/irq_dist_pick.sv
`timescale 1ns/1ps
module irq_dist_pick #(
  parameter int unsigned NUM_IRQ = 64,
  localparam int unsigned IDW    = $clog2(NUM_IRQ)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_IRQ-1:0]   cand_i,
  input  logic [NUM_IRQ*8-1:0] prio_i,
  output logic                 valid_o,
  output logic [IDW-1:0]       id_o,
  output logic [7:0]           prio_o
);
  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    prio_o  = '0;
    // strict less-than keeps the lowest ID on equal priority
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (cand_i[i] && (!valid_o || prio_i[8*i +: 8] < prio_o)) begin
        valid_o = 1'b1;
        id_o    = IDW'(i);
        prio_o  = prio_i[8*i +: 8];
      end
    end
  end

  p_hit_is_cand_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> cand_i[id_o]);
  p_hit_prio_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (prio_i[8*id_o +: 8] == prio_o));
  p_idle_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (id_o == '0 && prio_o == '0));
endmodule

// File: rtl/irq_dist.sv
`timescale 1ns/1ps
module irq_dist
  import irq_dist_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned NUM_CPU = 4,
  localparam int unsigned IDW     = $clog2(NUM_IRQ),
  localparam int unsigned NUM_SRC = NUM_IRQ - 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [11:0]            addr_i,
  input  logic [31:0]            wdata_i,
  output logic [31:0]            rdata_o,
  input  logic [NUM_SRC-1:0]     src_i,
  output logic [NUM_CPU-1:0]     hit_o,
  output logic [NUM_CPU*IDW-1:0] hit_id_o,
  output logic [NUM_CPU*8-1:0]   hit_prio_o
);
  region_e               rgn;
  logic                  wr, gen_q;
  logic                  wr_set_en, wr_clr_en, wr_set_pnd, wr_clr_pnd;
  logic                  wr_prio, wr_tgt, wr_cfg;
  logic [NUM_IRQ-1:0]    en, pend, edg;
  logic [NUM_IRQ*8-1:0]  prio_flat;
  logic [NUM_CPU-1:0]    tgt [NUM_IRQ];
  logic [31:0]           rd_d;
  logic                  unused_addr;

  assign unused_addr = ^addr_i[1:0];
  assign rgn        = region_of(addr_i);
  assign wr         = req_i & we_i;
  assign wr_set_en  = wr && rgn == RG_EN  && !addr_i[7];
  assign wr_clr_en  = wr && rgn == RG_EN  &&  addr_i[7];
  assign wr_set_pnd = wr && rgn == RG_PND && !addr_i[7];
  assign wr_clr_pnd = wr && rgn == RG_PND &&  addr_i[7];
  assign wr_prio    = wr && rgn == RG_PRIO;
  assign wr_tgt     = wr && rgn == RG_TGT;
  assign wr_cfg     = wr && rgn == RG_CFG;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       gen_q <= 1'b0;
    else if (wr && rgn == RG_CTRL)     gen_q <= wdata_i[0];
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    localparam int W32 = i / 32;
    localparam int B32 = i % 32;
    localparam int W4  = i / 4;
    localparam int B4  = i % 4;
    localparam int W16 = i / 16;
    localparam int B16 = i % 16;
    logic src;
    if (i < 16) begin : g_nosrc
      assign src = 1'b0;
    end else begin : g_src
      assign src = src_i[i-16];
    end

    irq_dist_line #(.ID(i), .NUM_CPU(NUM_CPU)) u_line (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .src_i     (src),
      .set_en_i  (wr_set_en  && addr_i[6:2] == 5'(W32) && wdata_i[B32]),
      .clr_en_i  (wr_clr_en  && addr_i[6:2] == 5'(W32) && wdata_i[B32]),
      .set_pnd_i (wr_set_pnd && addr_i[6:2] == 5'(W32) && wdata_i[B32]),
      .clr_pnd_i (wr_clr_pnd && addr_i[6:2] == 5'(W32) && wdata_i[B32]),
      .cfg_we_i  (wr_cfg  && addr_i[9:2] == 8'(W16)),
      .cfg_edge_i(wdata_i[2*B16+1]),
      .prio_we_i (wr_prio && addr_i[9:2] == 8'(W4)),
      .prio_i    (wdata_i[8*B4 +: 8]),
      .tgt_we_i  (wr_tgt  && addr_i[9:2] == 8'(W4)),
      .tgt_i     (wdata_i[8*B4 +: NUM_CPU]),
      .en_o      (en[i]),
      .pend_o    (pend[i]),
      .edge_o    (edg[i]),
      .prio_o    (prio_flat[8*i +: 8]),
      .tgt_o     (tgt[i])
    );
  end

  always_comb begin
    rd_d = '0;
    case (rgn)
      RG_CTRL: rd_d[0] = gen_q;
      RG_EN: for (int i = 0; i < NUM_IRQ; i++)
               if (i / 32 == int'(addr_i[6:2])) rd_d[i % 32] = en[i];
      RG_PND: for (int i = 0; i < NUM_IRQ; i++)
               if (i / 32 == int'(addr_i[6:2])) rd_d[i % 32] = pend[i];
      RG_PRIO: for (int i = 0; i < NUM_IRQ; i++)
               if (i / 4 == int'(addr_i[9:2])) rd_d[8*(i % 4) +: 8] = prio_flat[8*i +: 8];
      RG_TGT: for (int i = 0; i < NUM_IRQ; i++)
               if (i / 4 == int'(addr_i[9:2])) rd_d[8*(i % 4) +: NUM_CPU] = tgt[i];
      RG_CFG: for (int i = 0; i < NUM_IRQ; i++)
               if (i / 16 == int'(addr_i[9:2])) rd_d[2*(i % 16) + 1] = edg[i];
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_o <= '0;
    else if (req_i && !we_i)  rdata_o <= rd_d;
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_IRQ-1:0] cand;
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_cand
      assign cand[i] = gen_q & en[i] & pend[i] & tgt[i][c];
    end
    irq_dist_pick #(.NUM_IRQ(NUM_IRQ)) u_pick (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cand_i (cand),
      .prio_i (prio_flat),
      .valid_o(hit_o[c]),
      .id_o   (hit_id_o[c*IDW +: IDW]),
      .prio_o (hit_prio_o[c*8 +: 8])
    );
  end

  p_sgi_on_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_i && !we_i && addr_i == 12'h100) |-> rdata_o[15:0] == 16'hFFFF);
  p_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gen_q |-> hit_o == '0);
  p_hole_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_i && !we_i && addr_i[11:8] == 4'h3) |-> rdata_o == '0);
endmodule

// File: tb/irq_dist_test.sv
`timescale 1ns/1ps
module irq_dist_test;
  localparam int NI  = 48;
  localparam int NC  = 3;
  localparam int IDW = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0, we = 1'b0;
  logic [11:0]       addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NI-17:0]    src = '0;
  logic [NC-1:0]     hit;
  logic [NC*IDW-1:0] hit_id;
  logic [NC*8-1:0]   hit_prio;

  int n_chk = 0, n_err = 0;

  bit       m_en [NI];
  bit       m_pl [NI];
  bit       m_edge [NI];
  bit [7:0] m_prio [NI];
  bit [7:0] m_tgt [NI];
  bit       m_src [NI];
  bit       m_gen;

  always #5 clk = ~clk;

  irq_dist #(.NUM_IRQ(NI), .NUM_CPU(NC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .src_i(src), .hit_o(hit),
    .hit_id_o(hit_id), .hit_prio_o(hit_prio));

  function automatic bit m_pend(int i);
    return m_pl[i] | (!m_edge[i] & m_src[i]);
  endfunction

  function automatic bit [31:0] m_read(bit [11:0] a);
    bit [31:0] r = '0;
    if (a[11:10] == 2'b01 || a[11:10] == 2'b10) begin
      for (int k = 0; k < 4; k++) begin
        int id = int'(a[9:2]) * 4 + k;
        if (id < NI) r[8*k +: 8] = (a[11:10] == 2'b01) ? m_prio[id] : m_tgt[id];
      end
    end else if (a[11:10] == 2'b11) begin
      for (int k = 0; k < 16; k++) begin
        int id = int'(a[9:2]) * 16 + k;
        if (id < NI) r[2*k+1] = m_edge[id];
      end
    end else if (a[9:8] == 2'b01 || a[9:8] == 2'b10) begin
      for (int b = 0; b < 32; b++) begin
        int id = int'(a[6:2]) * 32 + b;
        if (id < NI) r[b] = (a[9:8] == 2'b01) ? m_en[id] : m_pend(id);
      end
    end else if (a[9:2] == 8'd0) begin
      r[0] = m_gen;
    end
    return r;
  endfunction

  task automatic model_write(bit [11:0] a, bit [31:0] d);
    if (a[11:10] == 2'b01 || a[11:10] == 2'b10) begin
      for (int k = 0; k < 4; k++) begin
        int id = int'(a[9:2]) * 4 + k;
        if (id < NI) begin
          if (a[11:10] == 2'b01) m_prio[id] = d[8*k +: 8];
          else                   m_tgt[id]  = d[8*k +: 8] & 8'((1 << NC) - 1);
        end
      end
    end else if (a[11:10] == 2'b11) begin
      for (int k = 0; k < 16; k++) begin
        int id = int'(a[9:2]) * 16 + k;
        if (id >= 16 && id < NI) m_edge[id] = d[2*k+1];
      end
    end else if (a[9:8] == 2'b01 || a[9:8] == 2'b10) begin
      for (int b = 0; b < 32; b++) begin
        int id = int'(a[6:2]) * 32 + b;
        if (id < NI && d[b]) begin
          if (a[9:8] == 2'b01) begin
            if (id >= 16) m_en[id] = !a[7];
          end else begin
            m_pl[id] = !a[7];
          end
        end
      end
    end else if (a[9:2] == 8'd0) begin
      m_gen = d[0];
    end
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(bit [11:0] a, bit [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd_chk(bit [11:0] a, string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    check(tag, rdata, m_read(a));
  endtask

  task automatic set_src(int id, bit v);
    @(negedge clk);
    src[id-16] = v;
    @(posedge clk);
    @(posedge clk);
    if (v && !m_src[id] && m_edge[id]) m_pl[id] = 1'b1;
    m_src[id] = v;
  endtask

  task automatic chk_hits(string tag);
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      bit bv = 1'b0;
      int bid = 0;
      bit [7:0] bp = '0;
      for (int i = 0; i < NI; i++)
        if (m_gen && m_en[i] && m_pend(i) && m_tgt[i][c] && (!bv || m_prio[i] < bp)) begin
          bv = 1'b1; bid = i; bp = m_prio[i];
        end
      check(tag, {15'b0, hit[c], 2'b0, hit_id[c*IDW +: IDW], hit_prio[c*8 +: 8]},
            {15'b0, bv, 8'(bid), bp});
    end
  endtask

  function automatic bit [11:0] rand_addr();
    int unsigned r = $urandom % 9;
    case (r)
      0: return 12'h000;
      1: return 12'h100 + 12'(4 * ($urandom % 3));
      2: return 12'h180 + 12'(4 * ($urandom % 3));
      3: return 12'h200 + 12'(4 * ($urandom % 3));
      4: return 12'h280 + 12'(4 * ($urandom % 3));
      5: return 12'h400 + 12'(4 * ($urandom % 13));
      6: return 12'h800 + 12'(4 * ($urandom % 13));
      7: return 12'hC00 + 12'(4 * ($urandom % 4));
      default: return 12'h300;
    endcase
  endfunction

  initial begin
    #1_000_000;
    n_chk++; n_err++;
    $display("FAIL R12 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NI; i++) begin
      m_en[i] = (i < 16); m_edge[i] = (i < 16); m_pl[i] = 0;
      m_prio[i] = 0; m_tgt[i] = 8'h01; m_src[i] = 0;
    end
    m_gen = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd_chk(12'h000, "R11 ctrl");
    rd_chk(12'h100, "R11 enable word0");
    check("R11 sgi enable value", rdata, 32'h0000FFFF);
    rd_chk(12'h104, "R11 enable word1");
    rd_chk(12'h200, "R11 pending");
    rd_chk(12'h420, "R11 priority");
    rd_chk(12'h820, "R11 target");
    check("R11 target value", rdata, 32'h01010101);
    rd_chk(12'hC00, "R1 cfg sgi");
    check("R1 cfg sgi value", rdata, 32'hAAAAAAAA);
    rd_chk(12'hC04, "R11 cfg level");
    chk_hits("R11 no hits");

    // R1 SGI enables stick
    bus_wr(12'h180, 32'hFFFFFFFF);
    rd_chk(12'h100, "R1 sgi enables after clear");
    bus_wr(12'hC00, 32'h00000000);
    rd_chk(12'hC00, "R1 sgi cfg after write");

    // R10 / R2 partial words
    bus_wr(12'h104, 32'hFFFFFFFF);
    rd_chk(12'h104, "R10 enable upper ids");
    check("R2 enable word1 value", rdata, 32'h0000FFFF);
    rd_chk(12'h108, "R10 empty enable word");
    bus_wr(12'h82C, 32'hFFFFFFFF);
    rd_chk(12'h82C, "R7 target mask width");
    check("R7 target value", rdata, 32'h07070707);
    rd_chk(12'h300, "R10 hole");
    bus_wr(12'h424, 32'h11223344);
    rd_chk(12'h424, "R6 priority lanes");
    check("R6 priority value", rdata, 32'h11223344);

    // R9 tie and priority
    bus_wr(12'h000, 32'h1);
    bus_wr(12'h820, 32'h02010101);
    bus_wr(12'h828, 32'h00000002);
    bus_wr(12'h420, 32'h50000000);
    bus_wr(12'h428, 32'h00000050);
    bus_wr(12'h204, 32'h00000108);
    chk_hits("R9 tie lower id");
    check("R9 cpu1 id35", {26'b0, hit_id[IDW +: IDW]}, 32'd35);
    bus_wr(12'h428, 32'h00000040);
    chk_hits("R9 lower value wins");
    check("R9 cpu1 id40", {26'b0, hit_id[IDW +: IDW]}, 32'd40);

    // R8 global gate
    bus_wr(12'h000, 32'h0);
    chk_hits("R8 gate off");
    bus_wr(12'h000, 32'h1);

    // R3 clear pending
    bus_wr(12'h284, 32'h00000100);
    rd_chk(12'h204, "R3 clear pending");
    check("R3 pending value", rdata, 32'h00000008);

    // R4 edge mode, ID 20 on CPU 2
    bus_wr(12'h100, 32'h00100000);
    bus_wr(12'h814, 32'h00000004);
    bus_wr(12'hC04, 32'h00000200);
    @(negedge clk);
    src[4] = 1'b1;
    @(negedge clk);
    check("R4 not yet pending", {31'b0, hit[2]}, 32'd0);
    @(negedge clk);
    check("R4 latched after two edges", {hit[2], 2'b0, hit_id[2*IDW +: IDW]}, {1'b1, 2'b0, 6'd20});
    m_src[20] = 1; m_pl[20] = 1;
    set_src(20, 0);
    chk_hits("R4 held after input low");
    bus_wr(12'h280, 32'h00100000);
    chk_hits("R4 cleared by software");

    // R5 level mode, ID 17 on CPU 2
    bus_wr(12'h100, 32'h00020000);
    bus_wr(12'h810, 32'h00000400);
    @(negedge clk);
    src[1] = 1'b1;
    @(negedge clk);
    check("R5 level pending", {hit[2], 2'b0, hit_id[2*IDW +: IDW]}, {1'b1, 2'b0, 6'd17});
    m_src[17] = 1;
    @(negedge clk);
    src[1] = 1'b0;
    @(negedge clk);
    check("R5 level released", {31'b0, hit[2]}, 32'd0);
    m_src[17] = 0;
    chk_hits("R5 model agrees");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int unsigned op = $urandom % 9;
      case (op)
        0: bus_wr(12'h100 + 12'(4 * ($urandom % 2)), $urandom & $urandom);
        1: bus_wr(12'h180 + 12'(4 * ($urandom % 2)), $urandom & $urandom & $urandom);
        2: bus_wr(12'h200 + 12'(4 * ($urandom % 2)), $urandom & $urandom & $urandom);
        3: bus_wr(12'h280 + 12'(4 * ($urandom % 2)), $urandom & $urandom);
        4: bus_wr(12'h400 + 12'(4 * ($urandom % 12)), $urandom);
        5: bus_wr(12'h800 + 12'(4 * ($urandom % 12)), $urandom);
        6: bus_wr(12'hC00 + 12'(4 * ($urandom % 3)), $urandom);
        7: begin
          int id = 16 + int'($urandom % 32);
          set_src(id, !m_src[id]);
        end
        default: bus_wr(12'h000, 32'(($urandom % 4) != 0));
      endcase
      chk_hits("R9 random arbitration");
      rd_chk(rand_addr(), "R12 random readback");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule